// File: doc/BRIEF.md
# Remote Terminal Status Word Builder

This block forms the 16-bit status word that a serial-bus remote terminal returns after each command. The subsystem reports its condition through a set of active-low flag pins: message error, terminal flag, service request, busy, subsystem flag and dynamic bus control accept. The block captures these pins in the cycle in which the command-valid strobe is high and holds them until the next strobe. The terminal address sits in the top field of the word. Encoding and transmitting the word on the bus are handled elsewhere.

On the same strobe the block decodes the received command word and drives three indicators, each held until the next command:
- a broadcast flag;
- a mode-command flag;
- an active-low flag for the dynamic bus control mode code.

A low message-error pin marks the message as illegal. The block then raises the suppress-data output, which tells the surrounding logic not to store the command, not to start a main RAM transfer and not to send data words after the status word.

The command word layout is as follows:
- bits 15:11 hold the address;
- bit 10 is transmit/receive (T/R);
- bits 9:5 hold the subaddress;
- bits 4:0 hold the word count or mode code.

Top module: `rt_status_builder`

## Requirements
- R1: While reset is held, and after it is released until the first strobe, `statusWord` equals `{termAddr, 11'b0}`. In the same period `suppressData`, `broadcastOut` and `modeCmdOut` are 0 and `dynBusCtrlN` is 1.
- R2: At a clock edge with `cmdValid` high, a pin at 0 sets its status bit and a pin at 1 clears it, visible after that edge. The pin-to-bit mapping is:
  - `svcReqN` drives bit 8 (service request);
  - `busyN` drives bit 3 (busy);
  - `subsysFlagN` drives bit 2 (subsystem flag);
  - `termFlagN` drives bit 0 (terminal flag).
- R3: At edges with `cmdValid` low, changes on any flag pin have no effect on `statusWord` or `suppressData`.
- R4: A strobe with `msgErrN` low sets status bit 10 and `suppressData`. A strobe with `msgErrN` high clears both.
- R5: Status bit 1 is set by a strobe only when `dynBusAcceptN` is 0 and the command is a dynamic bus control request. That request is a subaddress of 0 or 31, mode code 0 and T/R = 1.
- R6: A strobe whose command address field is 31 sets `broadcastOut` and status bit 4. Any other address clears both. Both hold until the next strobe.
- R7: A strobe whose subaddress is 0 or 31 sets `modeCmdOut`. Any other subaddress clears it. The value holds until the next strobe.
- R8: `dynBusCtrlN` goes low after a strobe carrying a dynamic bus control request (as defined in R5) and high after any other strobe. The value holds until the next strobe.
- R9: `statusWord[15:11]` always equals `termAddr`, and bits 9 and 7:5 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| termAddr | input | 5 | This terminal's address, static in operation |
| cmdWord | input | 16 | Received command word |
| cmdValid | input | 1 | High for a cycle when a validated command is present |
| msgErrN | input | 1 | Active-low message error |
| termFlagN | input | 1 | Active-low terminal flag |
| svcReqN | input | 1 | Active-low service request |
| busyN | input | 1 | Active-low subsystem busy |
| subsysFlagN | input | 1 | Active-low subsystem flag |
| dynBusAcceptN | input | 1 | Active-low dynamic bus control accept |
| statusWord | output | 16 | Assembled status word |
| suppressData | output | 1 | Message illegal: no storage, no RAM transfer, no data words |
| broadcastOut | output | 1 | Last command was a broadcast |
| modeCmdOut | output | 1 | Last command was a mode command |
| dynBusCtrlN | output | 1 | Active low: last command was a dynamic bus control request |

## Verification
The assertions assume two things about the inputs:
- `termAddr` stays constant after reset;
- `cmdWord` and the flag pins are steady around each clock edge.

Under these assumptions the flag bits of the word can only move at a strobe edge. The stimulus sets `termAddr` once before reset is released and drives every input half a period away from the sampling edge. It applies directed commands to hit each decode corner:
- broadcast address;
- subaddress 0 and subaddress 31;
- T/R = 0 versus T/R = 1;
- a non-mode subaddress carrying mode code 0.

It then applies a long run of random commands, pin values and idle gaps. During the gaps the pins keep changing, which exercises the hold behaviour.

// File: rtl/rtsw_pkg.sv
package rtsw_pkg;

  // Status word bit positions within the low 11-bit flag field
  localparam int BitMsgErr  = 10;
  localparam int BitInstr   = 9;
  localparam int BitSvcReq  = 8;
  localparam int BitBcast   = 4;
  localparam int BitBusy    = 3;
  localparam int BitSsFlag  = 2;
  localparam int BitDbcAcc  = 1;
  localparam int BitTermFlg = 0;
  localparam int FlagW      = 11;

  typedef struct packed {
    logic latchStatus;   // capture subsystem flag pins
    logic latchDecode;   // capture command decode indicators
  } ctrlStrobes_t;

  typedef struct packed {
    logic isBcast;
    logic isMode;
    logic isDbcReq;
  } cmdDecode_t;

  typedef struct packed {
    logic msgErrN;
    logic termFlagN;
    logic svcReqN;
    logic busyN;
    logic subsysFlagN;
    logic dynBusAcceptN;
  } flagPins_t;

endpackage

// File: rtl/rtsw_ctrl.sv
module rtsw_ctrl
  import rtsw_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int SUBA_W  = 5,
  parameter int COUNT_W = 5,
  localparam int CMD_W  = ADDR_W + 1 + SUBA_W + COUNT_W
) (
  input  logic [CMD_W-1:0] cmdWord,
  input  logic             cmdValid,
  output ctrlStrobes_t     strb,
  output cmdDecode_t       dec
);

  localparam int TrPos = SUBA_W + COUNT_W;

  logic [ADDR_W-1:0]  addrField;
  logic [SUBA_W-1:0]  subaField;
  logic [COUNT_W-1:0] codeField;
  logic               trBit;

  assign addrField = cmdWord[CMD_W-1 -: ADDR_W];
  assign trBit     = cmdWord[TrPos];
  assign subaField = cmdWord[COUNT_W +: SUBA_W];
  assign codeField = cmdWord[COUNT_W-1:0];

  always_comb begin
    dec.isBcast  = &addrField;
    dec.isMode   = (subaField == '0) || (&subaField);
    dec.isDbcReq = dec.isMode && (codeField == '0) && trBit;
  end

  always_comb begin
    strb.latchStatus = cmdValid;
    strb.latchDecode = cmdValid;
  end

endmodule

// File: rtl/rtsw_datapath.sv
module rtsw_datapath
  import rtsw_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int WORD_W = ADDR_W + FlagW
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  cmdDecode_t        dec,
  input  flagPins_t         pins,
  input  logic [ADDR_W-1:0] termAddr,
  output logic [WORD_W-1:0] statusWord,
  output logic              suppressData,
  output logic              broadcastOut,
  output logic              modeCmdOut,
  output logic              dynBusCtrlN
);

  logic msgErrQ, termFlagQ, svcReqQ, busyQ, ssFlagQ, dbcAccQ;
  logic bcastQ, modeQ, dbcReqQ;

  // Subsystem flags: captured only while the strobe is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgErrQ   <= 1'b0;
      termFlagQ <= 1'b0;
      svcReqQ   <= 1'b0;
      busyQ     <= 1'b0;
      ssFlagQ   <= 1'b0;
      dbcAccQ   <= 1'b0;
    end else if (strb.latchStatus) begin
      msgErrQ   <= !pins.msgErrN;
      termFlagQ <= !pins.termFlagN;
      svcReqQ   <= !pins.svcReqN;
      busyQ     <= !pins.busyN;
      ssFlagQ   <= !pins.subsysFlagN;
      dbcAccQ   <= !pins.dynBusAcceptN && dec.isDbcReq;
    end
  end

  // Command indicators: held until the next command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcastQ  <= 1'b0;
      modeQ   <= 1'b0;
      dbcReqQ <= 1'b0;
    end else if (strb.latchDecode) begin
      bcastQ  <= dec.isBcast;
      modeQ   <= dec.isMode;
      dbcReqQ <= dec.isDbcReq;
    end
  end

  always_comb begin
    statusWord                 = '0;
    statusWord[WORD_W-1 -: ADDR_W] = termAddr;
    statusWord[BitMsgErr]      = msgErrQ;
    statusWord[BitInstr]       = 1'b0;
    statusWord[BitSvcReq]      = svcReqQ;
    statusWord[BitBcast]       = bcastQ;
    statusWord[BitBusy]        = busyQ;
    statusWord[BitSsFlag]      = ssFlagQ;
    statusWord[BitDbcAcc]      = dbcAccQ;
    statusWord[BitTermFlg]     = termFlagQ;
  end

  assign suppressData = msgErrQ;
  assign broadcastOut = bcastQ;
  assign modeCmdOut   = modeQ;
  assign dynBusCtrlN  = !dbcReqQ;

  // R3: no strobe, no movement of the latched flag field
  a_r3_hold_between_strobes: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchStatus |=> $stable(statusWord[FlagW-1:0]) && $stable(suppressData));

  // R4: message error sets both the word bit and the suppress output
  a_r4_suppress_on_error: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchStatus && !pins.msgErrN |=> suppressData && statusWord[BitMsgErr]);

  // R5: accept bit only alongside a dynamic bus control request
  a_r5_accept_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[BitDbcAcc] |-> !dynBusCtrlN);

  // R6: broadcast indicator follows the decoded address of the strobed command
  a_r6_bcast_follows_cmd: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchDecode |=> broadcastOut == $past(dec.isBcast));

  // R8: a dynamic bus control request is always a mode command
  a_r8_dbc_is_mode: assert property (@(posedge clk) disable iff (!rstN)
    !dynBusCtrlN |-> modeCmdOut);

endmodule

// File: rtl/rt_status_builder.sv
module rt_status_builder
  import rtsw_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int SUBA_W  = 5,
  parameter int COUNT_W = 5,
  localparam int CMD_W  = ADDR_W + 1 + SUBA_W + COUNT_W,
  localparam int WORD_W = ADDR_W + FlagW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] termAddr,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              cmdValid,
  input  logic              msgErrN,
  input  logic              termFlagN,
  input  logic              svcReqN,
  input  logic              busyN,
  input  logic              subsysFlagN,
  input  logic              dynBusAcceptN,
  output logic [WORD_W-1:0] statusWord,
  output logic              suppressData,
  output logic              broadcastOut,
  output logic              modeCmdOut,
  output logic              dynBusCtrlN
);

  ctrlStrobes_t strb;
  cmdDecode_t   dec;
  flagPins_t    pins;

  always_comb begin
    pins.msgErrN       = msgErrN;
    pins.termFlagN     = termFlagN;
    pins.svcReqN       = svcReqN;
    pins.busyN         = busyN;
    pins.subsysFlagN   = subsysFlagN;
    pins.dynBusAcceptN = dynBusAcceptN;
  end

  rtsw_ctrl #(.ADDR_W(ADDR_W), .SUBA_W(SUBA_W), .COUNT_W(COUNT_W)) u_ctrl (
    .cmdWord (cmdWord),
    .cmdValid(cmdValid),
    .strb    (strb),
    .dec     (dec)
  );

  rtsw_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .dec         (dec),
    .pins        (pins),
    .termAddr    (termAddr),
    .statusWord  (statusWord),
    .suppressData(suppressData),
    .broadcastOut(broadcastOut),
    .modeCmdOut  (modeCmdOut),
    .dynBusCtrlN (dynBusCtrlN)
  );

endmodule

// File: tb/rt_status_builder_bench.sv
`timescale 1ns/1ps
module rt_status_builder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  termAddr = 5'h0B;
  logic [15:0] cmdWord = '0;
  logic        cmdValid = 1'b0;
  logic        msgErrN = 1'b1, termFlagN = 1'b1, svcReqN = 1'b1;
  logic        busyN = 1'b1, subsysFlagN = 1'b1, dynBusAcceptN = 1'b1;
  logic [15:0] statusWord;
  logic        suppressData, broadcastOut, modeCmdOut, dynBusCtrlN;

  int errors = 0;
  int checks = 0;
  bit cmpOn  = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  rt_status_builder u_rt_status_builder (
    .clk(clk), .rstN(rstN), .termAddr(termAddr), .cmdWord(cmdWord), .cmdValid(cmdValid),
    .msgErrN(msgErrN), .termFlagN(termFlagN), .svcReqN(svcReqN), .busyN(busyN),
    .subsysFlagN(subsysFlagN), .dynBusAcceptN(dynBusAcceptN),
    .statusWord(statusWord), .suppressData(suppressData), .broadcastOut(broadcastOut),
    .modeCmdOut(modeCmdOut), .dynBusCtrlN(dynBusCtrlN));

  // Behavioural reference model
  int eMe, eTf, eSr, eBusy, eSsf, eAcc, eBc, eMode, eDbc;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eMe = 0; eTf = 0; eSr = 0; eBusy = 0; eSsf = 0; eAcc = 0; eBc = 0; eMode = 0; eDbc = 0;
    end else if (cmdValid) begin
      int a, sa, mc, tr;
      a  = int'(cmdWord[15:11]);
      tr = int'(cmdWord[10]);
      sa = int'(cmdWord[9:5]);
      mc = int'(cmdWord[4:0]);
      eBc   = (a == 31) ? 1 : 0;
      eMode = (sa == 0 || sa == 31) ? 1 : 0;
      eDbc  = (eMode == 1 && mc == 0 && tr == 1) ? 1 : 0;
      eMe   = msgErrN ? 0 : 1;
      eTf   = termFlagN ? 0 : 1;
      eSr   = svcReqN ? 0 : 1;
      eBusy = busyN ? 0 : 1;
      eSsf  = subsysFlagN ? 0 : 1;
      eAcc  = (!dynBusAcceptN && eDbc == 1) ? 1 : 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int expWord();
    return (int'(termAddr) << 11) | (eMe << 10) | (eSr << 8) | (eBc << 4) |
           (eBusy << 3) | (eSsf << 2) | (eAcc << 1) | eTf;
  endfunction

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check("R9 address field", int'(statusWord[15:11]), int'(termAddr));
      check("R9 reserved zero", int'({statusWord[9], statusWord[7:5]}), 0);
      check("R4 message error bit", int'(statusWord[10]), eMe);
      check("R4 suppressData", int'(suppressData), eMe);
      check("R2 flag bits", int'({statusWord[8], statusWord[3], statusWord[2], statusWord[0]}),
            (eSr << 3) | (eBusy << 2) | (eSsf << 1) | eTf);
      check("R5 accept bit", int'(statusWord[1]), eAcc);
      check("R6 broadcast bit", int'(statusWord[4]), eBc);
      check("R6 broadcastOut", int'(broadcastOut), eBc);
      check("R7 modeCmdOut", int'(modeCmdOut), eMode);
      check("R8 dynBusCtrlN", int'(dynBusCtrlN), 1 - eDbc);
    end
  end

  // pin order: {msgErrN, termFlagN, svcReqN, busyN, subsysFlagN, dynBusAcceptN}
  task automatic setPins(input logic [5:0] p);
    {msgErrN, termFlagN, svcReqN, busyN, subsysFlagN, dynBusAcceptN} = p;
  endtask

  task automatic sendCmd(input logic [4:0] a, input logic tr, input logic [4:0] sa,
                         input logic [4:0] mc, input logic [5:0] p);
    @(negedge clk);
    cmdWord = {a, tr, sa, mc};
    setPins(p);
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state while held and just after release
    check("R1 statusWord in reset", int'(statusWord), int'({termAddr, 11'b0}));
    rstN = 1'b1;
    @(negedge clk);
    check("R1 statusWord after release", int'(statusWord), int'({termAddr, 11'b0}));
    check("R1 indicators after release",
          int'({suppressData, broadcastOut, modeCmdOut, dynBusCtrlN}), 1);
    cmpOn = 1'b1;

    sendCmd(5'h0B, 1'b0, 5'd3, 5'd4, 6'b000000);  // R2/R4: all pins active
    held = statusWord;
    // R3: pins toggle without a strobe
    setPins(6'b111111); @(negedge clk);
    setPins(6'b010101); @(negedge clk);
    check("R3 word held without strobe", int'(statusWord), int'(held));
    sendCmd(5'd31, 1'b0, 5'd2, 5'd1, 6'b111111);  // R6 broadcast
    sendCmd(5'h0B, 1'b1, 5'd0, 5'd0, 6'b111110);  // R5/R8 DBC via sa 0
    sendCmd(5'h0B, 1'b1, 5'd31, 5'd0, 6'b111110); // DBC via sa 31
    sendCmd(5'h0B, 1'b0, 5'd31, 5'd0, 6'b111110); // T/R=0: not DBC
    sendCmd(5'h0B, 1'b1, 5'd5, 5'd0, 6'b111110);  // non-mode sa: R7 low
    sendCmd(5'd31, 1'b1, 5'd0, 5'd0, 6'b011110);  // broadcast DBC with error
    sendCmd(5'h0B, 1'b1, 5'd0, 5'd0, 6'b111111);  // DBC, accept pin high
    for (int i = 0; i < 400; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if ($urandom_range(0, 3) == 0) w[9:5] = ($urandom_range(0, 1) == 1) ? 5'd31 : 5'd0;
      if ($urandom_range(0, 3) == 0) w[4:0] = 5'd0;
      sendCmd(w[15:11], w[10], w[9:5], w[4:0], 6'($urandom));
      for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
        setPins(6'($urandom)); cmdWord = 16'($urandom);
        @(negedge clk);
      end
    end
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule